// File: doc/BRIEF.md
# Dual Conversion-Result Queue with Interrupt Status

This block stores 12-bit conversion results produced by a step sequencer in two independent first-in first-out queues. Each result arrives with a queue-select bit that sends it to queue 0 or queue 1. Software drains a queue by reading that queue's data address. Each read removes one entry. Software can also read how many entries each queue holds, and it programs a per-queue fill level at which the queue raises a threshold event.

Queue events come from three sources: a threshold crossing, a push into a full queue, and a read from an empty queue. These events are gathered in one shared, sticky status register. The status register also collects three event pulses from the sequencer: sequence finished, sequence finished late, and result out of range. An enable register selects which status bits may raise the single interrupt output. Software clears a status bit by writing a one to it.

Top module: `smpq_pair`

## Requirements
- R1: After reset, both counts read 0, the status and enable registers read 0, both thresholds read 40 and `irq` is low.
- R2: A result pushed with `push_sel`=0 goes only to queue 0, which is read at 0x100. A result pushed with `push_sel`=1 goes only to queue 1, which is read at 0x200. Within each queue, results come out in the order they were pushed.
- R3: A read of a queue's data address returns the oldest result in bits [11:0], with bits [31:12] zero, and removes that entry. The counts at 0xE4 (queue 0) and 0xF0 (queue 1) give the number of stored entries.
- R4: Each queue holds 64 entries. A push into a full queue is dropped: the queue contents and count stay unchanged. The push sets status bit 3 (queue 0) or bit 6 (queue 1).
- R5: A data read from an empty queue returns 0, leaves the count at 0, and sets status bit 4 (queue 0) or bit 7 (queue 1).
- R6: The thresholds are read/write at 0xE8 (queue 0) and 0xF4 (queue 1). Status bit 2 (queue 0) or bit 5 (queue 1) sets on the cycle the count moves from below the threshold to at or above it. A count that is already at or above the threshold sets nothing further.
- R7: A pulse on `seq_miss` sets status bit 0, a pulse on `seq_done` sets bit 1, and a pulse on `range_evt` sets bit 8.
- R8: Writing to the status register at 0x28 clears each bit written as one and leaves each bit written as zero unchanged. An event that fires in the same cycle as a clear of its bit leaves the bit set.
- R9: The enable register is read/write at 0x2C. `irq` is a register that goes high one cycle after any status bit that is also enabled is set, and it stays low while no enabled bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | A conversion result is present this cycle |
| push_sel | input | 1 | Target queue of the result (0 or 1) |
| push_data | input | 12 | Conversion result |
| seq_done | input | 1 | Sequence-finished event pulse |
| seq_miss | input | 1 | Sequence-finished-late event pulse |
| range_evt | input | 1 | Out-of-range event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when it addresses a data port) |
| reg_addr | input | 10 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench fills queue 0 to exactly 64 entries and pushes one more, then drains the queue against a scoreboard. A design that overwrote the oldest entry or wrapped its count would return a result that was never accepted, or would read the wrong count. It reads an empty queue and expects zero together with the underflow bit, so a design that returned stale memory or let the count go below zero is caught. A low threshold is crossed once and then exceeded again after a clear, which exposes a level-sensitive threshold flag that keeps re-setting. A clear is made in the same cycle as a new event, and the interrupt is timed cycle by cycle, which catches a design where the clear wins or where the interrupt is combinational.

// File: rtl/smpq_pkg.sv
package smpq_pkg;
  localparam int NQ      = 2;
  localparam int NUM_EVT = 9;

  // fixed status bit positions
  localparam int EV_MISS  = 0;
  localparam int EV_DONE  = 1;
  localparam int EV_RANGE = 8;

  localparam int OFS_STAT = 'h28;
  localparam int OFS_EN   = 'h2C;

  function automatic int evt_thr(int q);
    return 2 + 3 * q;
  endfunction

  function automatic int evt_ovf(int q);
    return 3 + 3 * q;
  endfunction

  function automatic int evt_unf(int q);
    return 4 + 3 * q;
  endfunction

  function automatic int cnt_ofs(int q);
    return (q == 0) ? 'hE4 : 'hF0;
  endfunction

  function automatic int thr_ofs(int q);
    return cnt_ofs(q) + 4;
  endfunction

  function automatic int data_ofs(int q);
    return (q == 0) ? 'h100 : 'h200;
  endfunction

  // upward crossing of a fill level
  function automatic logic crossed(int unsigned prev, int unsigned nxt, int unsigned lvl);
    return (prev < lvl) && (nxt >= lvl);
  endfunction
endpackage

// File: rtl/smpq_fifo.sv
module smpq_fifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic [CNT_W-1:0]  thr_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              thr_evt_o,
  output logic              ovf_evt_o,
  output logic              unf_evt_o
);
  import smpq_pkg::*;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              full, empty, push_ok, pop_ok;

  assign full    = (count_o == CNT_W'(DEPTH));
  assign empty   = (count_o == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty;

  assign ovf_evt_o = push_i && full;
  assign unf_evt_o = pop_i && empty;

  always_comb begin
    cnt_nxt   = count_o + CNT_W'(push_ok) - CNT_W'(pop_ok);
    thr_evt_o = crossed(int'(count_o), int'(cnt_nxt), int'(thr_i));
  end

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count_o <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  assign head_o = empty ? '0 : mem[rd_ptr];

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));

  // R4
  ovf_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_o && !pop_i) |=> (count_o == CNT_W'(DEPTH)));

  // R5
  unf_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_evt_o && !push_i) |=> (count_o == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1) ||
              (count_o + 1'b1 == $past(count_o))));
endmodule

// File: rtl/smpq_irq.sv
module smpq_irq #(
  parameter int NUM_EVT = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic               en_wr_i,
  input  logic [NUM_EVT-1:0] en_wdata_i,
  output logic [NUM_EVT-1:0] status_o,
  output logic [NUM_EVT-1:0] enable_o,
  output logic               irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      enable_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_i) | evt_i;
      if (en_wr_i) enable_o <= en_wdata_i;
      irq_o <= |(status_o & enable_o);
    end
  end

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_o) & ~$past(clr_i)) & ~status_o) == '0));

  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(status_o & enable_o) != '0));
endmodule

// File: rtl/smpq_pair.sv
module smpq_pair #(
  parameter int DATA_W  = 12,
  parameter int DEPTH   = 64,
  parameter int ADDR_W  = 10,
  parameter int BUS_W   = 32,
  parameter int THR_RST = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic              push_sel,
  input  logic [DATA_W-1:0] push_data,
  input  logic              seq_done,
  input  logic              seq_miss,
  input  logic              range_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              irq
);
  import smpq_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0]  head_w  [NQ];
  logic [CNT_W-1:0]   cnt_w   [NQ];
  logic [CNT_W-1:0]   thr_q   [NQ];
  logic [NQ-1:0]      thr_evt, ovf_evt, unf_evt, push_q, pop_q;
  logic [NUM_EVT-1:0] evt_w, clr_w, status_w, enable_w;
  logic               hit_stat, hit_en;
  logic               wdata_unused;

  assign wdata_unused = ^reg_wdata;
  assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign hit_en   = (reg_addr == ADDR_W'(OFS_EN));

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign push_q[q] = push_valid && (push_sel == 1'(q));
    assign pop_q[q]  = reg_rd && (reg_addr == ADDR_W'(data_ofs(q)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q[q] <= CNT_W'(THR_RST);
      else if (reg_wr && reg_addr == ADDR_W'(thr_ofs(q))) thr_q[q] <= reg_wdata[CNT_W-1:0];
    end

    smpq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (push_q[q]),
      .data_i   (push_data),
      .pop_i    (pop_q[q]),
      .thr_i    (thr_q[q]),
      .head_o   (head_w[q]),
      .count_o  (cnt_w[q]),
      .thr_evt_o(thr_evt[q]),
      .ovf_evt_o(ovf_evt[q]),
      .unf_evt_o(unf_evt[q])
    );
  end

  always_comb begin
    evt_w           = '0;
    evt_w[EV_MISS]  = seq_miss;
    evt_w[EV_DONE]  = seq_done;
    evt_w[EV_RANGE] = range_evt;
    for (int q = 0; q < NQ; q++) begin
      evt_w[evt_thr(q)] = thr_evt[q];
      evt_w[evt_ovf(q)] = ovf_evt[q];
      evt_w[evt_unf(q)] = unf_evt[q];
    end
  end

  assign clr_w = (reg_wr && hit_stat) ? reg_wdata[NUM_EVT-1:0] : '0;

  smpq_irq #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_w),
    .clr_i     (clr_w),
    .en_wr_i   (reg_wr && hit_en),
    .en_wdata_i(reg_wdata[NUM_EVT-1:0]),
    .status_o  (status_w),
    .enable_o  (enable_w),
    .irq_o     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_stat) reg_rdata = BUS_W'(status_w);
    if (hit_en)   reg_rdata = BUS_W'(enable_w);
    for (int q = 0; q < NQ; q++) begin
      if (reg_addr == ADDR_W'(cnt_ofs(q)))  reg_rdata = BUS_W'(cnt_w[q]);
      if (reg_addr == ADDR_W'(thr_ofs(q)))  reg_rdata = BUS_W'(thr_q[q]);
      if (reg_addr == ADDR_W'(data_ofs(q))) reg_rdata = BUS_W'(head_w[q]);
    end
  end

  // R7
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> status_w[EV_DONE]);

  // R2
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push_q));
endmodule

// File: tb/tb_smpq_pair.sv
module tb_smpq_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0, push_sel = 1'b0;
  logic [11:0] push_data = '0;
  logic        seq_done = 1'b0, seq_miss = 1'b0, range_evt = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [11:0] sb0[$], sb1[$];

  always #4 clk = ~clk;

  smpq_pair dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [9:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // driver: push into DUT and into scoreboard model
  task automatic push(logic s, logic [11:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_sel = s; push_data = d;
    @(posedge clk); #1 push_valid = 1'b0;
    if (s == 1'b0) begin if (sb0.size() < 64) sb0.push_back(d); end
    else begin if (sb1.size() < 64) sb1.push_back(d); end
  endtask

  // monitor: pop from DUT and compare with scoreboard
  task automatic pop(logic s, string req);
    logic [31:0] v, e;
    rd(s ? 10'h200 : 10'h100, v);
    if (s == 1'b0) e = (sb0.size() > 0) ? 32'(sb0.pop_front()) : 32'h0;
    else           e = (sb1.size() > 0) ? 32'(sb1.pop_front()) : 32'h0;
    chk(req, v, e);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) seq_miss = 1'b1;
    if (which == 1) seq_done = 1'b1;
    if (which == 8) range_evt = 1'b1;
    @(posedge clk); #1 seq_miss = 1'b0; seq_done = 1'b0; range_evt = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    rd_chk("R1 status", 10'h028, 32'h0);
    rd_chk("R1 enable", 10'h02C, 32'h0);
    rd_chk("R1 count0", 10'h0E4, 32'h0);
    rd_chk("R1 count1", 10'h0F0, 32'h0);
    rd_chk("R1 thr0", 10'h0E8, 32'd40);
    rd_chk("R1 thr1", 10'h0F4, 32'd40);

    // R2 / R3 routing, ordering, counts
    push(0, 12'hA01); push(1, 12'h5B2); push(0, 12'hFFF);
    push(1, 12'h003); push(0, 12'h7C4);
    rd_chk("R3 count0", 10'h0E4, 32'd3);
    rd_chk("R3 count1", 10'h0F0, 32'd2);
    pop(1, "R2 q1 first");
    pop(0, "R2 q0 first");
    pop(0, "R3 q0 second upper bits zero");
    pop(1, "R2 q1 second");
    pop(0, "R2 q0 third");
    rd_chk("R3 count0 drained", 10'h0E4, 32'd0);
    rd_chk("R2 no events", 10'h028, 32'h0);

    // R5 underflow on queue 1
    pop(1, "R5 empty read returns zero");
    rd_chk("R5 count1 stays 0", 10'h0F0, 32'd0);
    rd_chk("R5 status bit7", 10'h028, 32'h080);

    // R8 write-one-to-clear
    wr(10'h028, 32'h000);
    rd_chk("R8 zero write keeps", 10'h028, 32'h080);
    wr(10'h028, 32'h080);
    rd_chk("R8 one clears", 10'h028, 32'h000);

    // R6 threshold crossing once
    wr(10'h0E8, 32'd3);
    rd_chk("R6 thr0 readback", 10'h0E8, 32'd3);
    push(0, 12'h111); push(0, 12'h222);
    rd_chk("R6 below threshold", 10'h028, 32'h000);
    push(0, 12'h333);
    rd_chk("R6 crossing sets bit2", 10'h028, 32'h004);
    wr(10'h028, 32'h004);
    push(0, 12'h444);
    rd_chk("R6 no re-set above", 10'h028, 32'h000);
    for (int i = 0; i < 4; i++) pop(0, "R6 drain");
    wr(10'h0E8, 32'd40);
    rd_chk("R6 thr0 restore", 10'h0E8, 32'd40);

    // R4 overflow on queue 0
    for (int i = 0; i < 64; i++) push(0, 12'(i * 37 + 5));
    rd_chk("R4 count full", 10'h0E4, 32'd64);
    rd_chk("R4 no overflow yet", 10'h028, 32'h004);
    push(0, 12'hBAD);
    rd_chk("R4 count unchanged", 10'h0E4, 32'd64);
    rd_chk("R4 overflow bit3", 10'h028, 32'h00C);
    for (int i = 0; i < 64; i++) pop(0, "R4 contents intact");
    rd_chk("R4 drained", 10'h0E4, 32'd0);
    wr(10'h028, 32'h1FF);

    // R7 sequencer events
    pulse(1); rd_chk("R7 done bit1", 10'h028, 32'h002);
    pulse(0); rd_chk("R7 miss bit0", 10'h028, 32'h003);
    pulse(8); rd_chk("R7 range bit8", 10'h028, 32'h103);
    wr(10'h028, 32'h1FF);
    rd_chk("R8 clear all", 10'h028, 32'h000);

    // R9 interrupt gating and latency
    wr(10'h02C, 32'h002);
    rd_chk("R9 enable readback", 10'h02C, 32'h002);
    pulse(0);
    @(posedge clk); #1 chk("R9 disabled bit no irq", 32'(irq), 32'h0);
    pulse(1);
    chk("R9 irq not same cycle", 32'(irq), 32'h0);
    @(posedge clk); #1 chk("R9 irq rises", 32'(irq), 32'h1);
    wr(10'h028, 32'h002);
    chk("R9 irq still registered", 32'(irq), 32'h1);
    @(posedge clk); #1 chk("R9 irq falls", 32'(irq), 32'h0);

    // R8 event wins over same-cycle clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 10'h028; reg_wdata = 32'h003; seq_done = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0; seq_done = 1'b0;
    rd_chk("R8 set wins", 10'h028, 32'h002);

    summary();
  end
endmodule